// File: doc/BRIEF.md
# Predicate and register transfer unit

This execution unit moves bits in both directions between a file of seven programmable one-bit predicate flags and a 32-bit general register value. The instruction word names one of two operations. A scatter copies the low seven bits of a chosen byte of the source register into the predicates. A pack collects the predicates into a byte and merges that byte into a copy of the source register. In both operations a 7-bit immediate mask limits the effect: it selects which predicates a scatter updates, and it selects which packed bits a pack keeps.

The unit takes one instruction at a time. The caller supplies the 64-bit instruction word, the source register value from the operand port and the current predicate values. Every result appears on registered write ports one clock after issue. The predicate file and the register file are outside the unit and receive the write enables and data. The unit always decodes from the predicate values presented in its issue cycle. An instruction that does not decode, or that requests the unsupported register mode, raises a flag and writes nothing.

Top module: `pred_xfer_unit`

## Requirements
- R1: An instruction is a scatter when `instr[63:48]` masked by 16'hFEF8 equals 16'h38F0. It is a pack when the same masked value equals 16'h38E8. Bits 56 and 50:48 are don't-care.
- R2: For a scatter with mode bit `instr[40]` = 0, let k = `instr[42:41]` and m = `instr[26:20]`. For each i from 0 to 6, `pred_we[i]` = m[i] and `pred_wdata[i]` = m[i] AND `src_val[8k+i]`.
- R3: A scatter never writes a register. `reg_we` stays 0 and `reg_wdata` stays 0.
- R4: For a pack with `instr[40]` = 0, bits 8k+6..8k of `reg_wdata` equal `pred_in` AND m, and `reg_we` = 1.
- R5: For a pack, bit 8k+7 of `reg_wdata` is always 0.
- R6: For a pack, every `reg_wdata` bit outside byte k equals the matching bit of `src_val`. `reg_waddr` equals `instr[7:0]`, and no predicate write enable is set.
- R7: When the opcode matches either pattern but `instr[40]` = 1, `illegal` = 1 and no write enable is set.
- R8: When the opcode matches neither pattern, `illegal` = 1 and no write enable is set.
- R9: The outputs register the result of the issue cycle. They are valid exactly one clock after `issue_valid`. `out_valid` equals the delayed `issue_valid`. All outputs are 0 in reset and in cycles with no issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Instruction presented this cycle |
| instr | input | 64 | Instruction word |
| src_val | input | 32 | Source register value from the operand port |
| pred_in | input | 7 | Current programmable predicate values |
| out_valid | output | 1 | Registered: result of last cycle's issue |
| illegal | output | 1 | Registered: undecodable or unsupported instruction |
| pred_we | output | 7 | Registered predicate write enables |
| pred_wdata | output | 7 | Registered predicate write values |
| reg_we | output | 1 | Registered destination register write enable |
| reg_waddr | output | 8 | Registered destination register index |
| reg_wdata | output | 32 | Registered destination register value |

## Verification
The assertions compare the outputs with the previous cycle's `instr` and `src_val`. They therefore take for granted that those inputs hold their issue-cycle values until the result appears one clock later. The bench meets this by changing inputs only at the falling edge, once per issued vector. The stimulus forces the opcode field onto each of the two patterns with random don't-care bits and also lets it run fully random. This keeps both legal operations, the unsupported mode and undecodable words well populated. Directed cases cover every byte selector with all-ones and all-zeros masks.

// File: rtl/pxu_pkg.sv
// Shared parameters, field positions and types for the predicate/register
// transfer unit. Assumes a 64-bit instruction word with a 16-bit opcode on top.
package pxu_pkg;
    localparam int INSTR_W  = 64;
    localparam int REG_W    = 32;
    localparam int NPRED    = 7;
    localparam int DST_W    = 8;
    localparam int BSEL_W   = 2;
    localparam int BYTE_W   = 8;

    localparam int OPC_LSB  = 48;
    localparam int MASK_LSB = 20;
    localparam int BSEL_LSB = 41;
    localparam int MODE_BIT = 40;
    localparam int DST_LSB  = 0;

    localparam logic [15:0] OPC_CARE    = 16'hFEF8;
    localparam logic [15:0] OPC_SCATTER = 16'h38F0;
    localparam logic [15:0] OPC_PACK    = 16'h38E8;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_SCATTER = 2'd1,
        OP_PACK    = 2'd2
    } xfer_op_e;

    typedef struct packed {
        xfer_op_e               op;
        logic                   mode_reg;
        logic [NPRED-1:0]       mask;
        logic [BSEL_W-1:0]      bsel;
        logic [DST_W-1:0]       dst;
    } xfer_dec_t;
endpackage

// File: rtl/pxu_decode.sv
// Opcode match and field extraction. Purely combinational; assumes the
// opcode patterns do not overlap (they differ in bits 52:51).
module pxu_decode
    import pxu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output xfer_dec_t          dec,
    output logic               bad
);
    logic [15:0] opc;

    // Match the opcode against both patterns and slice out fields.
    always_comb begin
        opc          = instr[OPC_LSB +: 16];
        dec.mask     = instr[MASK_LSB +: NPRED];
        dec.bsel     = instr[BSEL_LSB +: BSEL_W];
        dec.mode_reg = instr[MODE_BIT];
        dec.dst      = instr[DST_LSB +: DST_W];
        if ((opc & OPC_CARE) == OPC_SCATTER)   dec.op = OP_SCATTER;
        else if ((opc & OPC_CARE) == OPC_PACK) dec.op = OP_PACK;
        else                                   dec.op = OP_NONE;
        bad = (dec.op == OP_NONE) || dec.mode_reg;
    end
endmodule

// File: rtl/pxu_scatter.sv
// Scatter path: selects one byte of the source value and proposes a write of
// its low predicate-count bits, gated per bit by the mask and by enable.
module pxu_scatter
    import pxu_pkg::*;
(
    input  logic              en,
    input  logic [REG_W-1:0]  src,
    input  logic [BSEL_W-1:0] bsel,
    input  logic [NPRED-1:0]  mask,
    output logic [NPRED-1:0]  we,
    output logic [NPRED-1:0]  wd
);
    localparam int SH_W = $clog2(REG_W);
    logic [REG_W-1:0] shifted;
    logic [SH_W-1:0]  offs;

    // Bring the selected byte down to bit 0.
    always_comb begin
        offs    = SH_W'({bsel, 3'b000});
        shifted = src >> offs;
    end

    for (genvar i = 0; i < NPRED; i++) begin : g_bit
        // Per-predicate enable and value.
        assign we[i] = en & mask[i];
        assign wd[i] = en & mask[i] & shifted[i];
    end
endmodule

// File: rtl/pxu_pack.sv
// Pack path: gathers predicates into a byte, masks it and inserts it into the
// selected byte of the source value. The top bit of the byte is always zero.
module pxu_pack
    import pxu_pkg::*;
(
    input  logic [REG_W-1:0]  src,
    input  logic [BSEL_W-1:0] bsel,
    input  logic [NPRED-1:0]  mask,
    input  logic [NPRED-1:0]  preds,
    output logic [REG_W-1:0]  result
);
    localparam int SH_W = $clog2(REG_W);
    logic [BYTE_W-1:0] packed_b;
    logic [SH_W-1:0]   offs;
    logic [REG_W-1:0]  hole;

    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        if (i < NPRED) begin : g_pred
            assign packed_b[i] = preds[i] & mask[i];
        end else begin : g_zero
            assign packed_b[i] = 1'b0;
        end
    end

    // Clear the target byte and merge the packed byte into it.
    always_comb begin
        offs   = SH_W'({bsel, 3'b000});
        hole   = REG_W'({BYTE_W{1'b1}}) << offs;
        result = (src & ~hole) | (REG_W'(packed_b) << offs);
    end
endmodule

// File: rtl/pred_xfer_unit.sv
// Top of the predicate/register transfer unit. Decodes one instruction per
// cycle and registers all write-port outputs one clock after issue. Assumes
// the caller holds the predicate file; the always-true predicate is not part
// of pred_in and is never written.
module pred_xfer_unit
    import pxu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [REG_W-1:0]   src_val,
    input  logic [NPRED-1:0]   pred_in,
    output logic               out_valid,
    output logic               illegal,
    output logic [NPRED-1:0]   pred_we,
    output logic [NPRED-1:0]   pred_wdata,
    output logic               reg_we,
    output logic [DST_W-1:0]   reg_waddr,
    output logic [REG_W-1:0]   reg_wdata
);
    xfer_dec_t        dec;
    logic             bad;
    logic             do_scatter;
    logic             do_pack;
    logic [NPRED-1:0] s_we;
    logic [NPRED-1:0] s_wd;
    logic [REG_W-1:0] p_res;

    pxu_decode u_dec (.instr(instr), .dec(dec), .bad(bad));

    // Qualify the two operations with issue and supported mode.
    always_comb begin
        do_scatter = issue_valid && !bad && (dec.op == OP_SCATTER);
        do_pack    = issue_valid && !bad && (dec.op == OP_PACK);
    end

    pxu_scatter u_sc (
        .en(do_scatter), .src(src_val), .bsel(dec.bsel), .mask(dec.mask),
        .we(s_we), .wd(s_wd)
    );

    pxu_pack u_pk (
        .src(src_val), .bsel(dec.bsel), .mask(dec.mask), .preds(pred_in),
        .result(p_res)
    );

    // Output stage: capture the issue-cycle result, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            illegal    <= 1'b0;
            pred_we    <= '0;
            pred_wdata <= '0;
            reg_we     <= 1'b0;
            reg_waddr  <= '0;
            reg_wdata  <= '0;
        end else begin
            out_valid  <= issue_valid;
            illegal    <= issue_valid && bad;
            pred_we    <= s_we;
            pred_wdata <= s_wd;
            reg_we     <= do_pack;
            reg_waddr  <= do_pack ? dec.dst : '0;
            reg_wdata  <= do_pack ? p_res : '0;
        end
    end
endmodule

// File: rtl/pred_xfer_unit_chk.sv
// Checker for the transfer unit; relates registered outputs to the
// previous cycle's inputs. Assumes inputs hold through each issue cycle.
module pred_xfer_unit_chk
    import pxu_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               issue_valid,
    input logic [INSTR_W-1:0] instr,
    input logic [REG_W-1:0]   src_val,
    input logic [NPRED-1:0]   pred_in,
    input logic               out_valid,
    input logic               illegal,
    input logic [NPRED-1:0]   pred_we,
    input logic [NPRED-1:0]   pred_wdata,
    input logic               reg_we,
    input logic [DST_W-1:0]   reg_waddr,
    input logic [REG_W-1:0]   reg_wdata
);
    p_writes_need_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || (|pred_we) || illegal) |-> out_valid);

    p_illegal_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (pred_we == '0) && !reg_we);

    p_scatter_no_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|pred_we) |-> !reg_we);

    p_we_within_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|pred_we) |-> ((pred_we & ~$past(instr[MASK_LSB +: NPRED])) == '0));

    p_top_bit_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (reg_wdata[{$past(instr[BSEL_LSB +: BSEL_W]), 3'b111}] == 1'b0));

    p_keep_other_bytes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (((reg_wdata ^ $past(src_val)) &
                     ~(REG_W'(8'hFF) << {$past(instr[BSEL_LSB +: BSEL_W]), 3'b000})) == '0));
endmodule

bind pred_xfer_unit pred_xfer_unit_chk u_chk (.*);

// File: tb/pred_xfer_unit_test.sv
module pred_xfer_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [63:0] instr = '0;
    logic [31:0] src_val = '0;
    logic [6:0]  pred_in = '0;
    logic        out_valid, illegal, reg_we;
    logic [6:0]  pred_we, pred_wdata;
    logic [7:0]  reg_waddr;
    logic [31:0] reg_wdata;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    pred_xfer_unit uut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
        .src_val(src_val), .pred_in(pred_in), .out_valid(out_valid),
        .illegal(illegal), .pred_we(pred_we), .pred_wdata(pred_wdata),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic        v;
        logic        ill;
        logic [6:0]  pwe;
        logic [6:0]  pwd;
        logic        rwe;
        logic [7:0]  ra;
        logic [31:0] rd;
    } res_t;

    function automatic res_t model(input logic iv, input logic [63:0] ins,
                                   input logic [31:0] s, input logic [6:0] p);
        res_t r = '0;
        logic [15:0] o = ins[63:48] & 16'hFEF8;
        int k = int'(ins[42:41]);
        logic [6:0] m = ins[26:20];
        bit sc = (o == 16'h38F0);
        bit pk = (o == 16'h38E8);
        r.v = iv;
        if (!iv) return r;
        if ((!sc && !pk) || ins[40]) begin
            r.ill = 1'b1;
            return r;
        end
        if (sc) begin
            for (int i = 0; i < 7; i++) begin
                r.pwe[i] = m[i];
                r.pwd[i] = m[i] & s[8*k+i];
            end
        end else begin
            r.rwe = 1'b1;
            r.ra  = ins[7:0];
            r.rd  = s;
            for (int i = 0; i < 8; i++)
                r.rd[8*k+i] = (i < 7) ? (p[i] & m[i]) : 1'b0;
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [63:0] ins);
        logic [15:0] o = ins[63:48] & 16'hFEF8;
        if (o == 16'h38F0) return ins[40] ? "R7" : "R2";
        if (o == 16'h38E8) return ins[40] ? "R7" : "R4";
        return "R8";
    endfunction

    task automatic compare(input string tag, input res_t e);
        res_t a;
        a = {out_valid, illegal, pred_we, pred_wdata, reg_we, reg_waddr, reg_wdata};
        n_vec++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, a, e);
        end
    endtask

    task automatic apply(input string tag, input logic iv, input logic [63:0] ins,
                         input logic [31:0] s, input logic [6:0] p);
        res_t e;
        issue_valid = iv; instr = ins; src_val = s; pred_in = p;
        e = model(iv, ins, s, p);
        @(posedge clk);
        @(negedge clk);
        compare(tag, e);
    endtask

    function automatic logic [63:0] mk(input logic [15:0] pat, input logic [63:0] rnd);
        logic [63:0] x = rnd;
        x[63:48] = (rnd[63:48] & ~16'hFEF8) | pat;
        return x;
    endfunction

    function automatic logic [63:0] fld(input logic [15:0] pat, input logic mode,
                                        input logic [1:0] b, input logic [6:0] m,
                                        input logic [7:0] d);
        logic [63:0] x = '0;
        x[63:48] = pat; x[40] = mode; x[42:41] = b; x[26:20] = m; x[7:0] = d;
        return x;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        compare("R9 reset", '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: idle cycle with junk inputs produces all zeros
        apply("R9 idle", 1'b0, fld(16'h38E8, 1'b0, 2'd1, 7'h7F, 8'h11), 32'hFFFF_FFFF, 7'h7F);
        // R1: don't-care bits set still decode
        apply("R1", 1'b1, fld(16'h38F0 | 16'h0107, 1'b0, 2'd0, 7'h7F, 8'h0), 32'h0000_0055, 7'h00);
        apply("R1", 1'b1, fld(16'h38E8 | 16'h0107, 1'b0, 2'd2, 7'h7F, 8'h3C), 32'h1234_5678, 7'h5A);
        for (int b = 0; b < 4; b++) begin
            apply("R2", 1'b1, fld(16'h38F0, 1'b0, 2'(b), 7'h7F, 8'h0), 32'hA5C3_96F0, 7'h00);
            apply("R2", 1'b1, fld(16'h38F0, 1'b0, 2'(b), 7'h00, 8'h0), 32'hFFFF_FFFF, 7'h00);
            apply("R3", 1'b1, fld(16'h38F0, 1'b0, 2'(b), 7'h2B, 8'h99), 32'hFFFF_FFFF, 7'h7F);
            apply("R5", 1'b1, fld(16'h38E8, 1'b0, 2'(b), 7'h7F, 8'h01), 32'hFFFF_FFFF, 7'h7F);
            apply("R6", 1'b1, fld(16'h38E8, 1'b0, 2'(b), 7'h00, 8'hFE), 32'hDEAD_BEEF, 7'h7F);
            apply("R4", 1'b1, fld(16'h38E8, 1'b0, 2'(b), 7'h55, 8'h42), 32'h0000_0000, 7'h7F);
        end
        apply("R7", 1'b1, fld(16'h38F0, 1'b1, 2'd1, 7'h7F, 8'h0), 32'hFFFF_FFFF, 7'h7F);
        apply("R7", 1'b1, fld(16'h38E8, 1'b1, 2'd3, 7'h7F, 8'h7), 32'hFFFF_FFFF, 7'h7F);
        apply("R8", 1'b1, fld(16'h38D8, 1'b0, 2'd0, 7'h7F, 8'h7), 32'hFFFF_FFFF, 7'h7F);
        apply("R8", 1'b1, fld(16'h0000, 1'b0, 2'd0, 7'h7F, 8'h7), 32'hFFFF_FFFF, 7'h7F);
        for (int n = 0; n < 3000; n++) begin
            logic [63:0] rnd = {$urandom, $urandom};
            logic [63:0] ins;
            int kind = int'($urandom_range(0, 9));
            if (kind < 4)      ins = mk(16'h38F0, rnd);
            else if (kind < 8) ins = mk(16'h38E8, rnd);
            else               ins = rnd;
            if ($urandom_range(0, 4) != 0) ins[40] = 1'b0;
            if ($urandom_range(0, 15) == 0)
                apply("R9 idle", 1'b0, ins, $urandom, 7'($urandom));
            else
                apply(tag_of(ins), 1'b1, ins, $urandom, 7'($urandom));
        end
        issue_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        compare("R9 drain", '0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule